// File: doc/BRIEF.md
# Conditional Test-and-Skip Unit

This block resolves a single-condition test instruction into the address of the next instruction. A decoded test code picks one of six conditions: a storage word equal to zero in its magnitude bits, the same word not zero, the least significant accumulator bit, the accumulator overflow bit P, the divide-check trigger, or one of six sense switches. When the chosen condition holds, the following instruction is skipped: the program counter advances by two instead of one.

The divide-check test works the other way round from the others. A trigger that is set makes it fall through and clear the trigger, with a one-cycle clear strobe. A trigger that is clear makes it skip. The sense-switch test takes no operand field. The instruction address itself selects the switch, and any address outside the six assigned codes reads as a switch that is off. A request is presented with a one-cycle valid strobe. The next program counter, the clear strobe and a done pulse are registered and appear on the following clock edge.

Top module: `skip_unit`

## Requirements
- R1: With op_i = 0 (zero test), the block skips when stor_word_i[34:0] is all zero. Bit 35 is the sign and is ignored. Otherwise it falls through.
- R2: With op_i = 1 (non-zero test), the block skips when stor_word_i[34:0] holds any one. Otherwise it falls through, and the sign bit 35 is ignored.
- R3: With op_i = 2 (low-order test), the block skips exactly when acc_i[0] is one. acc_i[0] is accumulator position 35, and acc_i[37:35] are S, Q, P.
- R4: With op_i = 3 (P-bit test), the block skips exactly when acc_i[35] (the P bit) is one.
- R5: With op_i = 4 (divide-check test) and div_chk_i = 1, the block falls through and pulses div_clr_o together with done_o. With div_chk_i = 0 it skips and div_clr_o stays low. div_clr_o is never high for any other opcode.
- R6: With op_i = 5 (sense-switch test), address octal 161+k (k = 0..5) selects sense_sw_i[k]. The block skips when that switch is one.
- R7: A sense-switch test whose addr_i is outside octal 161..166 falls through, whatever the switch inputs are.
- R8: next_pc_o is pc_i+1 on fall-through and pc_i+2 on skip, taken modulo 2^15.
- R9: op_i values 6 and 7 fall through (pc_i+1) and never pulse div_clr_o.
- R10: done_o, next_pc_o and div_clr_o update on the first rising edge after valid_i is sampled high. done_o is a single-cycle pulse, and next_pc_o holds its value while valid_i is low.
- R11: While rst_ni is low, done_o, div_clr_o and next_pc_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Test code |
| stor_word_i | input | 36 | Storage word, bit 35 sign |
| acc_i | input | 38 | Accumulator S,Q,P,1-35 (bit 37 down to 0) |
| div_chk_i | input | 1 | Divide-check trigger state |
| sense_sw_i | input | 6 | Sense switches 1..6 on bits 0..5 |
| addr_i | input | 15 | Instruction address field |
| pc_i | input | 15 | Current program counter |
| next_pc_o | output | 15 | Next program counter |
| div_clr_o | output | 1 | Clear strobe for the divide-check trigger |
| done_o | output | 1 | Result-valid pulse |

## Verification
Some properties are checked by assertions on every cycle. These cover the one-cycle latency from valid to done, the absence of done without a request, next_pc_o holding between requests, the clear strobe never appearing without done, the step always being one or two words, the zero-test outcome, and at most one switch selected. The per-opcode skip polarity is shown only by the bench's vectors. The same holds for the sign bit being ignored, the P bit being kept apart from position 35, the inverted divide-check sense, the switch-address decode edges, reserved opcodes and address wrap.

// File: rtl/skip_unit_pkg.sv
package skip_unit_pkg;
  localparam int ADDR_W = 15;
  localparam int WORD_W = 36;
  localparam int ACC_W  = 38;
  localparam int NUM_SW = 6;
  localparam logic [ADDR_W-1:0] SW_BASE = 15'o161;

  typedef enum logic [2:0] {
    OP_ZERO    = 3'd0,
    OP_NONZERO = 3'd1,
    OP_LOWBIT  = 3'd2,
    OP_PBIT    = 3'd3,
    OP_DIVCHK  = 3'd4,
    OP_SWITCH  = 3'd5
  } test_op_e;
endpackage

// File: rtl/skip_sw_select.sv
module skip_sw_select #(
  parameter int ADDR_W = 15,
  parameter int NUM_SW = 6,
  parameter logic [ADDR_W-1:0] BASE = 15'o161
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_SW-1:0] sw_i,
  output logic              sw_on_o
);
  logic [NUM_SW-1:0] sel;

  for (genvar k = 0; k < NUM_SW; k++) begin : g_dec
    assign sel[k] = (addr_i == BASE + ADDR_W'(k));
  end

  assign sw_on_o = |(sel & sw_i);

  // R6: fixed codes never select two switches
  always_comb begin
    p_sw_onehot_r6: assert ($onehot0(sel));
  end
endmodule

// File: rtl/skip_cond_eval.sv
module skip_cond_eval
  import skip_unit_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int ACC_W  = 38
) (
  input  logic [2:0]        op_i,
  input  logic [WORD_W-1:0] stor_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              div_chk_i,
  input  logic              sw_on_i,
  output logic              skip_o,
  output logic              clr_o
);
  localparam int MAG_W = WORD_W - 1;
  localparam int P_POS = ACC_W - 3;

  logic mag_zero;
  assign mag_zero = (stor_i[MAG_W-1:0] == '0);

  always_comb begin
    skip_o = 1'b0;
    clr_o  = 1'b0;
    case (op_i)
      OP_ZERO:    skip_o = mag_zero;
      OP_NONZERO: skip_o = !mag_zero;
      OP_LOWBIT:  skip_o = acc_i[0];
      OP_PBIT:    skip_o = acc_i[P_POS];
      OP_DIVCHK: begin
        skip_o = !div_chk_i;
        clr_o  = div_chk_i;
      end
      OP_SWITCH:  skip_o = sw_on_i;
      default:    skip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/skip_pc_step.sv
module skip_pc_step #(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              skip_i,
  output logic [ADDR_W-1:0] next_pc_o
);
  assign next_pc_o = pc_i + (skip_i ? ADDR_W'(2) : ADDR_W'(1));
endmodule

// File: rtl/skip_unit.sv
module skip_unit
  import skip_unit_pkg::*;
#(
  parameter int ADDR_W = skip_unit_pkg::ADDR_W,
  parameter int WORD_W = skip_unit_pkg::WORD_W,
  parameter int ACC_W  = skip_unit_pkg::ACC_W,
  parameter int NUM_SW = skip_unit_pkg::NUM_SW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [WORD_W-1:0] stor_word_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              div_chk_i,
  input  logic [NUM_SW-1:0] sense_sw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              div_clr_o,
  output logic              done_o
);
  logic              sw_on, skip, clr_req;
  logic [ADDR_W-1:0] pc_calc;

  skip_sw_select #(.ADDR_W(ADDR_W), .NUM_SW(NUM_SW), .BASE(SW_BASE)) i_sw (
    .addr_i (addr_i),
    .sw_i   (sense_sw_i),
    .sw_on_o(sw_on)
  );

  skip_cond_eval #(.WORD_W(WORD_W), .ACC_W(ACC_W)) i_cond (
    .op_i     (op_i),
    .stor_i   (stor_word_i),
    .acc_i    (acc_i),
    .div_chk_i(div_chk_i),
    .sw_on_i  (sw_on),
    .skip_o   (skip),
    .clr_o    (clr_req)
  );

  skip_pc_step #(.ADDR_W(ADDR_W)) i_step (
    .pc_i     (pc_i),
    .skip_i   (skip),
    .next_pc_o(pc_calc)
  );

  // skip trigger latched late; next address formed from it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o <= '0;
      div_clr_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o    <= valid_i;
      div_clr_o <= valid_i & clr_req;
      if (valid_i) next_pc_o <= pc_calc;
    end
  end

  p_done_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  p_no_spurious_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  p_pc_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(next_pc_o));
  p_clr_with_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_clr_o |-> done_o);
  p_pc_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (next_pc_o == $past(pc_i) + ADDR_W'(1)) ||
                (next_pc_o == $past(pc_i) + ADDR_W'(2)));
  p_zero_skip_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0) |=>
      ((next_pc_o == $past(pc_i) + ADDR_W'(2)) == ($past(stor_word_i[WORD_W-2:0]) == '0)));
endmodule

// File: tb/test_skip_unit.sv
module test_skip_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  typedef struct packed {
    logic [7:0]  rq;
    logic [2:0]  op;
    logic [35:0] stor;
    logic [37:0] acc;
    logic        dc;
    logic [5:0]  sw;
    logic [14:0] addr;
    logic [14:0] pc;
    logic [14:0] exp_pc;
    logic        exp_clr;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R1 zero test
    '{8'd1, 3'd0, 36'h0,          38'h0, 1'b0, 6'h0, 15'd0, 15'd100, 15'd102, 1'b0},
    '{8'd1, 3'd0, 36'h8_0000_0000, 38'h0, 1'b0, 6'h0, 15'd0, 15'd100, 15'd102, 1'b0},
    '{8'd1, 3'd0, 36'h1,          38'h0, 1'b0, 6'h0, 15'd0, 15'd100, 15'd101, 1'b0},
    // R2 non-zero test
    '{8'd2, 3'd1, 36'h1,          38'h0, 1'b0, 6'h0, 15'd0, 15'd200, 15'd202, 1'b0},
    '{8'd2, 3'd1, 36'h8_0000_0000, 38'h0, 1'b0, 6'h0, 15'd0, 15'd200, 15'd201, 1'b0},
    // R3 low-order bit
    '{8'd3, 3'd2, 36'h0, 38'h1,           1'b0, 6'h0, 15'd0, 15'd300, 15'd302, 1'b0},
    '{8'd3, 3'd2, 36'h0, 38'h08_0000_0000, 1'b0, 6'h0, 15'd0, 15'd300, 15'd301, 1'b0},
    // R4 P bit
    '{8'd4, 3'd3, 36'h0, 38'h08_0000_0000, 1'b0, 6'h0, 15'd0, 15'd400, 15'd402, 1'b0},
    '{8'd4, 3'd3, 36'h0, 38'h37_FFFF_FFFF, 1'b0, 6'h0, 15'd0, 15'd400, 15'd401, 1'b0},
    // R5 divide check
    '{8'd5, 3'd4, 36'h0, 38'h0, 1'b1, 6'h0, 15'd0, 15'd500, 15'd501, 1'b1},
    '{8'd5, 3'd4, 36'h0, 38'h0, 1'b0, 6'h0, 15'd0, 15'd500, 15'd502, 1'b0},
    // R6 sense switches
    '{8'd6, 3'd5, 36'h0, 38'h0, 1'b0, 6'b000001, 15'o161, 15'd600, 15'd602, 1'b0},
    '{8'd6, 3'd5, 36'h0, 38'h0, 1'b0, 6'b100000, 15'o166, 15'd600, 15'd602, 1'b0},
    '{8'd6, 3'd5, 36'h0, 38'h0, 1'b0, 6'b011111, 15'o166, 15'd600, 15'd601, 1'b0},
    // R7 out-of-range switch codes
    '{8'd7, 3'd5, 36'h0, 38'h0, 1'b0, 6'b111111, 15'o160, 15'd700, 15'd701, 1'b0},
    '{8'd7, 3'd5, 36'h0, 38'h0, 1'b0, 6'b111111, 15'o167, 15'd700, 15'd701, 1'b0},
    // R8 wrap
    '{8'd8, 3'd0, 36'h0, 38'h0, 1'b0, 6'h0, 15'd0, 15'h7FFF, 15'h0001, 1'b0},
    '{8'd8, 3'd1, 36'h5, 38'h0, 1'b0, 6'h0, 15'd0, 15'h7FFE, 15'h0000, 1'b0},
    // R9 reserved op
    '{8'd9, 3'd6, 36'h0, 38'h1, 1'b1, 6'h3F, 15'o161, 15'd900, 15'd901, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [35:0] stor_word_i = '0;
  logic [37:0] acc_i = '0;
  logic        div_chk_i = 1'b0;
  logic [5:0]  sense_sw_i = '0;
  logic [14:0] addr_i = '0;
  logic [14:0] pc_i = '0;
  logic [14:0] next_pc_o;
  logic        div_clr_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  skip_unit i_skip_unit (
    .clk_i, .rst_ni, .valid_i, .op_i, .stor_word_i, .acc_i, .div_chk_i,
    .sense_sw_i, .addr_i, .pc_i, .next_pc_o, .div_clr_o, .done_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = v.op; stor_word_i = v.stor; acc_i = v.acc;
    div_chk_i = v.dc; sense_sw_i = v.sw; addr_i = v.addr; pc_i = v.pc;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11 pc", 32'(next_pc_o), 0);
    check("R11 done", 32'(done_o), 0);
    check("R11 clr", 32'(div_clr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 idle done", 32'(done_o), 0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R%0d vec %0d pc", VECS[i].rq, i), 32'(next_pc_o), 32'(VECS[i].exp_pc));
      check($sformatf("R%0d vec %0d clr", VECS[i].rq, i), 32'(div_clr_o), 32'(VECS[i].exp_clr));
      check($sformatf("R10 vec %0d done", i), 32'(done_o), 1);
    end

    // R10 single pulse, hold while idle, inputs change with valid low
    pc_i = 15'd1234; op_i = 3'd0;
    @(negedge clk_i);
    check("R10 done drop", 32'(done_o), 0);
    check("R10 pc hold", 32'(next_pc_o), 32'(VECS[NV-1].exp_pc));
    check("R5 no clr idle", 32'(div_clr_o), 0);

    // R10 back-to-back requests
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 3'd4; div_chk_i = 1'b1; pc_i = 15'd50;
    @(negedge clk_i);
    check("R5 b2b clr", 32'(div_clr_o), 1);
    check("R10 b2b pc1", 32'(next_pc_o), 51);
    op_i = 3'd2; acc_i = 38'h1; pc_i = 15'd60;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R10 b2b pc2", 32'(next_pc_o), 62);
    check("R5 b2b clr2", 32'(div_clr_o), 0);
    check("R10 b2b done", 32'(done_o), 1);

    // R11 reset mid-run
    rst_ni = 1'b0;
    #1;
    check("R11 async pc", 32'(next_pc_o), 0);
    check("R11 async done", 32'(done_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule